// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block collects 16-bit command words from a three-wire serial link: a data line, a serial clock and an active-low frame sync. All three wires are brought into the system clock domain through two-flop synchronizers. Serial clock edges are detected in that domain. Each falling edge of the serial clock samples one data bit, most significant bit first. When a word is complete, the block presents it on a parallel output together with a valid strobe that lasts one system clock cycle. Decoding the word's fields is left to the logic downstream.

A static mode input selects one of two framing rules.

- **Strict framing:** the sync line must stay low across all sixteen bits. The word is released only when sync rises again. If sync rises early, the partial word is thrown away.
- **Pulse framing:** a short low pulse on sync is enough to open a frame. The word is released as soon as its sixteenth bit arrives, whatever sync is doing by then.

A pass-through output repeats the incoming data stream sixteen serial clocks later, so that several receivers can share one link in a chain. A gate input forces this output low.

Top module: `sword_rx`

## Requirements
- R1: While reset is asserted and directly after it, `word_valid`, `word_out` and `chain_out` are all 0.
- R2: A word is made of 16 bits, each sampled on a falling edge of `sclk_in`. The first bit sampled after a frame opens becomes `word_out[15]` and the sixteenth becomes `word_out[0]`.
- R3: With `mcu_mode` = 1, a word whose sixteen bits arrived while `sync_n_in` stayed low is released only after `sync_n_in` rises. No `word_valid` is produced while sync is still low.
- R4: With `mcu_mode` = 1, a rise of `sync_n_in` before the sixteenth falling clock edge discards the partial word. No `word_valid` follows, and `word_out` keeps its previous value.
- R5: With `mcu_mode` = 0, a low pulse on `sync_n_in` opens a frame even if sync returns high before any bit is sampled. The word is released right after its sixteenth falling clock edge.
- R6: A falling edge of `sync_n_in` while a frame is already open restarts the bit count at zero. The next sixteen bits form the word.
- R7: With `chain_en` = 1, after the n-th falling edge of `sclk_in` since reset, `chain_out` equals the bit sampled on falling edge n-16. It is 0 while n is 16 or less. Every falling edge counts, whether or not a frame is open.
- R8: With `chain_en` = 0, `chain_out` is 0. The 16-stage delay line keeps shifting, so re-enabling the output shows the stream delayed by 16.
- R9: `word_valid` is high for exactly one system clock cycle per released word.
- R10: Falling clock edges while no frame is open do not release a word and do not change `word_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcu_mode | input | 1 | 1 selects strict framing, 0 selects pulse framing |
| chain_en | input | 1 | Enables the pass-through output |
| sclk_in | input | 1 | Asynchronous serial clock |
| sync_n_in | input | 1 | Asynchronous active-low frame sync |
| sdata_in | input | 1 | Asynchronous serial data |
| word_out | output | 16 | Last released word |
| word_valid | output | 1 | One-cycle strobe when a word is released |
| chain_out | output | 1 | Serial data delayed by 16 serial clocks, gated |

## Verification
A bit counter that drifts shows up at the ports in one of three ways. A word may arrive rotated or with wrong bits. It may arrive early, in strict mode before sync rises. Or it may be missing altogether. The scoreboard catches each of these at the first strobe it affects, and a missing word is caught at the end of the run. A delay line that is off by one stage produces a wrong `chain_out` bit within the first seventeen serial clocks. Framing state that survives an abort shows up as a stray strobe on the next clock edge outside a frame.

// File: rtl/sword_rx.sv
module sword_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mcu_mode,
  input  logic         chain_en,
  input  logic         sclk_in,
  input  logic         sync_n_in,
  input  logic         sdata_in,
  output logic [W-1:0] word_out,
  output logic         word_valid,
  output logic         chain_out
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic ck1, ck2, ck3, sy1, sy2, sy3, d1, d2;
  logic sc_fall, sy_fall, sy_rise;
  logic open, full, chain_q;
  logic [CW-1:0] cnt;
  logic [W-1:0] shreg, dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ck1, ck2, ck3} <= 3'b111;
      {sy1, sy2, sy3} <= 3'b111;
      {d1, d2} <= 2'b00;
    end else begin
      {ck1, ck2, ck3} <= {sclk_in, ck1, ck2};
      {sy1, sy2, sy3} <= {sync_n_in, sy1, sy2};
      {d1, d2} <= {sdata_in, d1};
    end
  end

  assign sc_fall = ck3 & ~ck2;
  assign sy_fall = sy3 & ~sy2;
  assign sy_rise = ~sy3 & sy2;
  assign chain_out = chain_en & chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly <= '0;
      chain_q <= 1'b0;
    end else if (sc_fall) begin
      dly <= {dly[W-2:0], d2};
      chain_q <= dly[W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open <= 1'b0;
      full <= 1'b0;
      cnt <= '0;
      shreg <= '0;
      word_out <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (sy_fall) begin
        open <= 1'b1;
        full <= 1'b0;
        cnt <= '0;
      end else if (open) begin
        if (mcu_mode && sy_rise) begin
          open <= 1'b0;
          full <= 1'b0;
          if (full) begin
            word_out <= shreg;
            word_valid <= 1'b1;
          end
        end else if (sc_fall && !full) begin
          shreg <= {shreg[W-2:0], d2};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            if (mcu_mode) full <= 1'b1;
            else begin
              open <= 1'b0;
              word_out <= {shreg[W-2:0], d2};
              word_valid <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r8_chain_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |-> !chain_out);
  a_r3_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && mcu_mode) |-> $past(sy_rise));
  a_r5_commit_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !mcu_mode) |-> $past(sc_fall));
  a_r7_chain_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sc_fall) && $stable(chain_en)) |-> $stable(chain_out));
  a_r10_no_strobe_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && !sy_fall) |=> !word_valid);
endmodule

// File: tb/sword_rx_test.sv
`timescale 1ns/1ps
module sword_rx_test;
  logic clk = 0, rst_n = 0, mcu_mode = 1, chain_en = 1;
  logic sclk_in = 1, sync_n_in = 1, sdata_in = 0;
  logic [15:0] word_out;
  logic word_valid, chain_out;
  int checks = 0, errors = 0, nvalid = 0;
  bit done = 0, prev_valid = 0;
  logic [15:0] expq[$];
  string tagq[$];
  bit hist[$];

  sword_rx uut (.clk(clk), .rst_n(rst_n), .mcu_mode(mcu_mode), .chain_en(chain_en),
    .sclk_in(sclk_in), .sync_n_in(sync_n_in), .sdata_in(sdata_in),
    .word_out(word_out), .word_valid(word_valid), .chain_out(chain_out));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input bit b);
    bit e;
    int n;
    sdata_in = b;
    wait_n(6);
    sclk_in = 0;
    hist.push_back(b);
    wait_n(6);
    n = hist.size();
    e = (chain_en && n >= 17) ? hist[n-17] : 1'b0;
    chk(chain_out == e, chain_en ? "R7 chain delay" : "R8 chain gated", chain_out, e);
    sclk_in = 1;
  endtask

  task automatic send_bits(input logic [15:0] w, input int nb);
    for (int i = 15; i > 15 - nb; i--) drive_bit(w[i]);
  endtask

  task automatic expect_word(input logic [15:0] w, input string tag);
    expq.push_back(w);
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid && prev_valid) chk(0, "R9 strobe width", 2, 1);
      if (word_valid && !prev_valid) begin
        nvalid++;
        if (expq.size() == 0) chk(0, "R10 unexpected word", word_out, 0);
        else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(word_out == e, t, word_out, e);
        end
      end
      prev_valid = word_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int v;
    wait_n(5);
    chk(word_valid == 0 && word_out == 0 && chain_out == 0, "R1 reset state", word_out, 0);
    rst_n = 1;
    wait_n(5);
    chk(word_valid == 0 && word_out == 0 && chain_out == 0, "R1 after reset", word_out, 0);

    // R3: strict framing, release on sync rise only
    expect_word(16'hA53C, "R2 R3 strict word");
    sync_n_in = 0; wait_n(6);
    send_bits(16'hA53C, 16);
    v = nvalid;
    wait_n(20);
    chk(nvalid == v, "R3 no early release", nvalid, v);
    sync_n_in = 1; wait_n(10);
    chk(nvalid == v + 1, "R3 release on rise", nvalid, v + 1);

    // R4: abort on early sync rise
    v = nvalid;
    sync_n_in = 0; wait_n(6);
    send_bits(16'hFFFF, 9);
    sync_n_in = 1; wait_n(12);
    chk(nvalid == v, "R4 aborted no strobe", nvalid, v);
    chk(word_out == 16'hA53C, "R4 word kept", word_out, 16'hA53C);

    // R2: bit order with lone LSB
    expect_word(16'h0001, "R2 lsb last");
    sync_n_in = 0; wait_n(6);
    send_bits(16'h0001, 16);
    sync_n_in = 1; wait_n(10);

    // R10: clocks with no frame open
    v = nvalid;
    send_bits(16'hB800, 5);
    wait_n(10);
    chk(nvalid == v && word_out == 16'h0001, "R10 idle clocks", word_out, 16'h0001);

    // R5: pulse framing
    mcu_mode = 0;
    expect_word(16'h8000, "R5 pulse word");
    sync_n_in = 0; wait_n(4); sync_n_in = 1; wait_n(4);
    v = nvalid;
    send_bits(16'h8000, 16);
    chk(nvalid == v + 1, "R5 release after bit 16", nvalid, v + 1);

    // R6: restart on second sync fall
    expect_word(16'h1234, "R6 restarted word");
    sync_n_in = 0; wait_n(4); sync_n_in = 1; wait_n(4);
    send_bits(16'hFE00, 7);
    sync_n_in = 0; wait_n(4); sync_n_in = 1; wait_n(4);
    send_bits(16'h1234, 16);

    // R8: gated pass-through, then re-enabled
    chain_en = 0;
    wait_n(4);
    expect_word(16'h5AC3, "R5 gated word");
    sync_n_in = 0; wait_n(4); sync_n_in = 1; wait_n(4);
    send_bits(16'h5AC3, 16);
    chain_en = 1;
    wait_n(4);
    expect_word(16'h0F0F, "R7 chained word");
    sync_n_in = 0; wait_n(4); sync_n_in = 1; wait_n(4);
    send_bits(16'h0F0F, 16);

    wait_n(20);
    chk(expq.size() == 0, "R2 all words seen", expq.size(), 0);
    summary();
  end
endmodule